// File: doc/BRIEF.md
# Dual Baud Clock Control Unit

This block is a small bus-mapped controller that sits beside a UART-style serial chip. It holds one 8-bit control register that software can write but not read. From that register it produces two independent clock enables, one for the transmitter and one for the receiver. Each enable runs at 64 times its selected baud rate. The block also decides whether the serial chip's data lines reach an external serial port or a tape interface, and it drives a tape motor relay.

A free-running 1.2288 MHz reference enable is divided down per channel. Each channel takes its rate from a 3-bit code, and a lower code gives a faster rate. When tape mode is selected, both channels ignore their codes and use a fixed 1200 baud rate. Each output is a single-cycle pulse that lands on a reference enable. When a write changes a channel's effective divisor, that channel's count restarts.

Top module: `dual_baud_ctrl`

## Requirements
- R1: A write (`bus_cs` and `bus_wr` high at a rising clock edge) to any of the eight addresses selected by `bus_addr` loads `bus_wdata` into the single control register. `bus_rdata` is always 0.
- R2: In a cycle without a write, the register keeps its value, even when `bus_cs` or `bus_wr` is high alone.
- R3: Register bit 7 drives `motor_on`, and 1 means the motor relay is on.
- R4: When bit 6 is 1 (serial mode), `port_txd` follows `sc_txd`, `sc_rxd` follows `port_rxd`, and `tape_txd` sits at 1.
- R5: When bit 6 is 0 (tape mode), `tape_txd` follows `sc_txd`, `sc_rxd` follows `tape_rxd`, and `port_txd` sits at 1.
- R6: In serial mode, the transmit code sits in bits 2..0 and the receive code in bits 5..3. Codes 0 to 7 divide the reference enable by 1, 2, 4, 8, 16, 64, 128 and 256 respectively.
- R7: Each baud output is high for exactly one cycle, only in a cycle where `ref_en` is high, and once for every divisor-count of reference enables.
- R8: In tape mode, both channels divide by 16 whatever the rate fields hold. A write that only alters the rate fields while in tape mode does not disturb either count.
- R9: A write that changes a channel's effective divisor restarts that channel. The next `ref_en` counts as the first enable of a new period, so the first pulse after the write comes on the divisor-th enable.
- R10: After reset the register is 0x00, which means tape mode with the motor off. Each channel's first pulse comes on the 16th `ref_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Chip select for the 8-address window |
| bus_addr | input | AW (3) | Address within the window; all addresses reach the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, always zero |
| ref_en | input | 1 | 1.2288 MHz reference clock enable |
| tx_baud_en | output | 1 | Transmit clock enable pulse (64x baud) |
| rx_baud_en | output | 1 | Receive clock enable pulse (64x baud) |
| sc_txd | input | 1 | Transmit data from the serial chip |
| sc_rxd | output | 1 | Receive data to the serial chip |
| port_txd | output | 1 | Transmit data to the external serial port |
| port_rxd | input | 1 | Receive data from the external serial port |
| tape_txd | output | 1 | Transmit data to the tape interface |
| tape_rxd | input | 1 | Receive data from the tape interface |
| motor_on | output | 1 | Tape motor relay drive |

## Verification
A corrupted control bit becomes visible at the ports in the same cycle. A flipped mode bit shows up at once on the routed data lines, and a flipped motor bit shows up at once on `motor_on`. A wrong divider count or a restart flag left standing is only exposed at the next expected or unexpected baud pulse, which can be up to 256 reference enables later. For that reason the bench compares both enables against a behavioural model on every clock, over long runs at each rate. It also runs short directed sequences that pin down the first pulse after reset and after a rate change.

// File: rtl/dual_baud_ctrl.sv
module dual_baud_ctrl #(
  parameter int          AW        = 3,
  parameter int          CW        = 8,
  parameter logic [2:0]  TAPE_CODE = 3'd4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cs,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          ref_en,
  output logic          tx_baud_en,
  output logic          rx_baud_en,
  input  logic          sc_txd,
  output logic          sc_rxd,
  output logic          port_txd,
  input  logic          port_rxd,
  output logic          tape_txd,
  input  logic          tape_rxd,
  output logic          motor_on
);

  localparam int NCH = 2;

  logic [7:0] ctl;
  logic       we;
  logic       serial_mode;
  logic [2:0] eff_code [NCH];
  logic [2:0] nxt_code [NCH];
  logic [NCH-1:0] tick;

  function automatic logic [3:0] code_shift(input logic [2:0] c);
    return (c > 3'd4) ? {1'b0, c} + 4'd1 : {1'b0, c};
  endfunction

  assign we          = bus_cs && bus_wr;
  assign serial_mode = ctl[6];

  always_ff @(posedge clk) begin
    if (!rst_n)  ctl <= 8'h00;
    else if (we) ctl <= bus_wdata;
  end

  assign bus_rdata = '0;
  assign motor_on  = ctl[7];
  assign port_txd  = serial_mode ? sc_txd : 1'b1;
  assign tape_txd  = serial_mode ? 1'b1 : sc_txd;
  assign sc_rxd    = serial_mode ? port_rxd : tape_rxd;

  assign eff_code[0] = serial_mode  ? ctl[2:0]       : TAPE_CODE;
  assign eff_code[1] = serial_mode  ? ctl[5:3]       : TAPE_CODE;
  assign nxt_code[0] = bus_wdata[6] ? bus_wdata[2:0] : TAPE_CODE;
  assign nxt_code[1] = bus_wdata[6] ? bus_wdata[5:3] : TAPE_CODE;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] cnt;
    logic          pend;
    logic [CW:0]   div;
    logic [CW-1:0] base;

    assign div     = (CW+1)'(1) << code_shift(eff_code[i]);
    assign base    = pend ? '0 : cnt;
    assign tick[i] = ref_en && ({1'b0, base} == div - (CW+1)'(1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt  <= '0;
        pend <= 1'b0;
      end else begin
        if (ref_en) begin
          cnt  <= tick[i] ? '0 : base + CW'(1);
          pend <= 1'b0;
        end
        if (we && nxt_code[i] != eff_code[i]) pend <= 1'b1;
      end
    end

    p_count_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_en && !pend) |=> $stable(cnt));
  end

  assign tx_baud_en = tick[0];
  assign rx_baud_en = tick[1];

  p_tx_on_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_baud_en |-> ref_en);
  p_rx_on_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_baud_en |-> ref_en);
  p_any_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && bus_wr && bus_addr != '0) |=> motor_on == $past(bus_wdata[7]));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_cs && bus_wr) |=> ($stable(motor_on) && $stable(ctl)));

endmodule

// File: tb/dual_baud_ctrl_test.sv
`timescale 1ns/1ps
module dual_baud_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_cs = 0, bus_wr = 0, ref_en = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic tx_baud_en, rx_baud_en, sc_txd = 1, sc_rxd, port_txd, port_rxd = 1, tape_txd, tape_rxd = 1, motor_on;

  always #4 clk = ~clk;

  dual_baud_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_en(ref_en),
    .tx_baud_en(tx_baud_en), .rx_baud_en(rx_baud_en), .sc_txd(sc_txd), .sc_rxd(sc_rxd),
    .port_txd(port_txd), .port_rxd(port_rxd), .tape_txd(tape_txd), .tape_rxd(tape_rxd),
    .motor_on(motor_on));

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [7:0] m_ctl;
  int m_k [2];
  bit m_p [2];
  logic s_tx, s_rx;

  function automatic int divisor(input logic [2:0] c);
    case (c)
      3'd0: return 1;   3'd1: return 2;   3'd2: return 4;   3'd3: return 8;
      3'd4: return 16;  3'd5: return 64;  3'd6: return 128; default: return 256;
    endcase
  endfunction

  function automatic int m_div(input logic [7:0] r, input int ch);
    if (!r[6]) return 16;
    return divisor(ch == 0 ? r[2:0] : r[5:3]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
  endtask

  task automatic step(input bit cs, input bit wr, input logic [2:0] a, input logic [7:0] d, input bit re);
    int e_tx, e_rx;
    @(negedge clk);
    bus_cs = cs; bus_wr = wr; bus_addr = a; bus_wdata = d; ref_en = re;
    sc_txd = 1'($urandom); port_rxd = 1'($urandom); tape_rxd = 1'($urandom);
    #1;
    e_tx = (re && (((m_p[0] ? 0 : m_k[0]) + 1) == m_div(m_ctl, 0))) ? 1 : 0;
    e_rx = (re && (((m_p[1] ? 0 : m_k[1]) + 1) == m_div(m_ctl, 1))) ? 1 : 0;
    s_tx = tx_baud_en; s_rx = rx_baud_en;
    chk("R6 R7 tx_baud_en", int'(tx_baud_en), e_tx);
    chk("R6 R7 rx_baud_en", int'(rx_baud_en), e_rx);
    chk("R3 motor_on", int'(motor_on), int'(m_ctl[7]));
    chk("R4 R5 port_txd", int'(port_txd), m_ctl[6] ? int'(sc_txd) : 1);
    chk("R4 R5 tape_txd", int'(tape_txd), m_ctl[6] ? 1 : int'(sc_txd));
    chk("R4 R5 sc_rxd", int'(sc_rxd), m_ctl[6] ? int'(port_rxd) : int'(tape_rxd));
    chk("R1 bus_rdata", int'(bus_rdata), 0);
    @(posedge clk);
    for (int c = 0; c < 2; c++) begin
      if (re) begin
        int k = m_p[c] ? 0 : m_k[c];
        k++;
        if (k == m_div(m_ctl, c)) k = 0;
        m_k[c] = k; m_p[c] = 0;
      end
    end
    if (cs && wr) begin
      for (int c = 0; c < 2; c++)
        if (m_div(d, c) != m_div(m_ctl, c)) m_p[c] = 1;
      m_ctl = d;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bus_cs = 0; bus_wr = 0; ref_en = 0;
    repeat (3) @(posedge clk);
    m_ctl = 8'h00; m_k[0] = 0; m_k[1] = 0; m_p[0] = 0; m_p[1] = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int first_tx, first_rx, ntx, nrx;
    do_reset();
    #1;
    chk("R10 reset motor_on", int'(motor_on), 0);
    chk("R10 reset port_txd idle", int'(port_txd), 1);

    // R10 and R8: tape divisor 16; rate-only write in tape mode leaves counts alone
    ntx = 0; nrx = 0; first_tx = 0; first_rx = 0;
    for (int n = 1; n <= 32; n++) begin
      step(n == 11, n == 11, 3'd5, 8'h3F, 1);
      if (s_tx) begin ntx++; if (first_tx == 0) first_tx = n; end
      if (s_rx) begin nrx++; if (first_rx == 0) first_rx = n; end
    end
    chk("R10 first tx pulse enable", first_tx, 16);
    chk("R10 first rx pulse enable", first_rx, 16);
    chk("R8 tx pulses in 32 enables", ntx, 2);
    chk("R8 rx pulses in 32 enables", nrx, 2);

    // R9: switch to serial, tx code 3 (div 8), rx code 0 (div 1)
    step(1, 1, 3'd2, 8'h43, 0);
    first_tx = 0; nrx = 0;
    for (int n = 1; n <= 8; n++) begin
      step(0, 0, 3'd0, 8'h00, 1);
      if (s_tx && first_tx == 0) first_tx = n;
      if (s_rx) nrx++;
    end
    chk("R9 first tx pulse after restart", first_tx, 8);
    chk("R9 rx pulses at divisor 1", nrx, 8);

    // R2: strobes alone do not write
    step(1, 1, 3'd7, 8'hC0, 0);
    for (int n = 0; n < 20; n++) step(n % 2, (n + 1) % 2, 3'(n), 8'h00, 1);
    #1;
    chk("R2 motor held without write", int'(motor_on), 1);
    chk("R2 serial routing held", int'(tape_txd), 1);

    // R6 sweep of each code on both channels
    for (int c = 0; c < 8; c++) begin
      step(1, 1, 3'(c), {2'b01, 3'(7 - c), 3'(c)}, 0);
      ntx = 0;
      for (int n = 0; n < 512; n++) begin
        step(0, 0, 3'd0, 8'h00, 1);
        if (s_tx) ntx++;
      end
      chk("R6 tx pulses in 512 enables", ntx, 512 / divisor(3'(c)));
    end

    // mixed traffic against the model
    for (int seg = 0; seg < 3; seg++) begin
      for (int n = 0; n < 20000; n++) begin
        bit w = ($urandom % 97) == 0;
        bit re = (seg == 0) ? 1'b1 : (seg == 1) ? (n % 3 == 0) : 1'($urandom);
        step(w | 1'($urandom % 5 == 0), w, 3'($urandom), 8'($urandom), re);
      end
    end

    do_reset();
    #1;
    chk("R10 second reset motor_on", int'(motor_on), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule